// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns a decoded instruction into the operand it names and the effective address it used. A one-cycle `start` pulse presents a 3-bit mode code, an address field, a register index and an indirection depth. The unit can read a small register file through a combinational read port. It can also read memory through a request/valid handshake. It uses the program counter that is presented with the instruction.

The mode codes are: 0 immediate, 1 direct, 2 memory-indirect, 3 register, 4 register-indirect, 5 displacement, 6 PC-relative, and 7 reserved. Immediate and register modes finish in one cycle and never touch memory. The memory modes first form an address and then read the operand at that address. In memory-indirect mode the unit follows one to three pointer levels before it reads the operand. It raises `done` for one cycle, with the operand and effective address valid in that same cycle. All address arithmetic wraps modulo 2^AW.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 (immediate): `operand` = `ea` = A, no memory read, and `done` rises in the cycle after `start`.
- R2: Mode 3 (register): `operand` = reg[R], `ea` = R zero-extended, no memory read, and `done` rises in the cycle after `start`.
- R3: Mode 1 (direct): `ea` = A, exactly one memory read at A, and `operand` = mem[A].
- R4: Mode 2 (memory-indirect): the depth input selects the number of pointer levels. Codes 0 and 1 give one level, 2 gives two and 3 gives three. Each level replaces the pointer by mem[pointer], starting from A. `ea` is the final pointer and `operand` = mem[ea]. The total number of reads is the level count plus one.
- R5: Mode 4 (register-indirect): `ea` = reg[R], exactly one read, and `operand` = mem[ea].
- R6: Mode 5 (displacement): `ea` = (A + reg[R]) mod 2^16, exactly one read, and `operand` = mem[ea].
- R7: Mode 6 (PC-relative): `ea` = (A + pc) mod 2^16, exactly one read, and `operand` = mem[ea].
- R8: Mode 7 (reserved): `done` and `err` are both high in the cycle after `start`, with no memory read and `operand` = `ea` = 0.
- R9: `mem_req` stays high with an unchanged `mem_addr` until `mem_valid` is seen. Only one read is outstanding at a time.
- R10: `done` lasts exactly one cycle. `err` is high only together with `done` for mode 7.
- R11: A `start` that arrives while an operation is in progress is ignored and does not change that operation's result.
- R12: While reset is applied, `done`, `err` and `mem_req` are low, and `operand` and `ea` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 3 | Addressing mode code |
| afield | input | AW | Instruction address field A |
| rfield | input | RW | Instruction register field R |
| depth | input | DW | Indirection level code |
| pc | input | AW | Current program counter |
| rf_sel | output | RW | Register file read index |
| rf_data | input | AW | Register file read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | AW | Read data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved mode flag, with done |
| operand | output | AW | Resulting operand |
| ea | output | AW | Resulting effective address |

## Verification
The bench builds the block with AW=16, RW=3 and DW=2. With AW=16, address sums that cross 0xFFFF come from short vectors, so the wrap is easy to exercise. With DW=2, every indirection code from 0 to 3 can be applied, which reaches the full three-level pointer chain. The bench's memory answers after zero, one or two wait cycles, so it tests that requests hold steady while they wait. A start pulse in the middle of a three-level chain checks that the unit ignores it while busy.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int RW = 3,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] afield,
  input  logic [RW-1:0] rfield,
  input  logic [DW-1:0] depth,
  input  logic [AW-1:0] pc,
  output logic [RW-1:0] rf_sel,
  input  logic [AW-1:0] rf_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] operand,
  output logic [AW-1:0] ea
);
  localparam logic [2:0] M_IMM = 3'd0, M_DIR = 3'd1, M_IND = 3'd2, M_REG = 3'd3,
                         M_RIND = 3'd4, M_DISP = 3'd5, M_REL = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_FIN} st_t;

  st_t           st;
  logic [DW-1:0] left;
  logic [AW-1:0] addr;
  logic          busy;

  assign busy     = (st != S_IDLE);
  assign rf_sel   = rfield;
  assign mem_req  = busy;
  assign mem_addr = addr;
  assign ea       = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      left    <= '0;
      addr    <= '0;
      operand <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          case (mode)
            M_IMM: begin
              addr    <= afield;
              operand <= afield;
              done    <= 1'b1;
            end
            M_DIR: begin
              addr <= afield;
              st   <= S_FIN;
            end
            M_IND: begin
              addr <= afield;
              left <= (depth == '0) ? DW'(1) : depth;
              st   <= S_PTR;
            end
            M_REG: begin
              addr    <= {{(AW-RW){1'b0}}, rfield};
              operand <= rf_data;
              done    <= 1'b1;
            end
            M_RIND: begin
              addr <= rf_data;
              st   <= S_FIN;
            end
            M_DISP: begin
              addr <= afield + rf_data;
              st   <= S_FIN;
            end
            M_REL: begin
              addr <= afield + pc;
              st   <= S_FIN;
            end
            default: begin
              addr    <= '0;
              operand <= '0;
              done    <= 1'b1;
              err     <= 1'b1;
            end
          endcase
        end
        S_PTR: if (mem_valid) begin
          addr <= mem_rdata;
          left <= left - DW'(1);
          if (left == DW'(1)) st <= S_FIN;
        end
        S_FIN: if (mem_valid) begin
          operand <= mem_rdata;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    mode,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          err
);
  assert_fast_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mode == 3'd0)) |=> (done && !mem_req));

  assert_fast_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mode == 3'd3)) |=> (done && !mem_req));

  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mode == 3'd7)) |=> (done && err && !mem_req));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !mem_valid) |=> (!done && mem_req));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .done(done), .err(err)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  localparam int AW = 16, RW = 3, DW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    mode = '0;
  logic [AW-1:0] afield = '0;
  logic [RW-1:0] rfield = '0;
  logic [DW-1:0] depth = '0;
  logic [AW-1:0] pc = '0;
  logic [RW-1:0] rf_sel;
  logic [AW-1:0] rf_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  logic          done, err;
  logic [AW-1:0] operand, ea;

  int nchk = 0, nfail = 0, nreads = 0, lat = 0, wcnt = 0, cyc = 0;
  logic [AW-1:0] a0 = '0;

  always #10 clk = ~clk;

  ea_gen #(.AW(AW), .RW(RW), .DW(DW)) i_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .afield(afield),
    .rfield(rfield), .depth(depth), .pc(pc), .rf_sel(rf_sel), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .done(done), .err(err), .operand(operand), .ea(ea)
  );

  function automatic logic [AW-1:0] memf(logic [AW-1:0] a);
    return a * 16'd5 + 16'h0123;
  endfunction

  function automatic logic [AW-1:0] regf(logic [RW-1:0] i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  assign rf_data = regf(rf_sel);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
      wcnt <= 0;
    end else if (mem_req) begin
      if (wcnt == 0) a0 <= mem_addr;
      if (wcnt >= lat) begin
        if (wcnt > 0) chk("R9", "address held while waiting", 32'(mem_addr), 32'(a0));
        mem_valid <= 1'b1;
        mem_rdata <= memf(mem_addr);
        nreads++;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  function automatic string tag(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R2";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // {mode, depth, r, a, pc}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {3'd0, 2'd0, 3'd0, 16'h1234, 16'h0000},
    {3'd3, 2'd0, 3'd5, 16'hAAAA, 16'h0000},
    {3'd1, 2'd0, 3'd0, 16'h0040, 16'h0000},
    {3'd2, 2'd1, 3'd0, 16'h0100, 16'h0000},
    {3'd2, 2'd0, 3'd0, 16'h0200, 16'h0000},
    {3'd2, 2'd2, 3'd0, 16'h0300, 16'h0000},
    {3'd2, 2'd3, 3'd0, 16'hFFF0, 16'h0000},
    {3'd4, 2'd0, 3'd2, 16'h0000, 16'h0000},
    {3'd5, 2'd0, 3'd7, 16'hF000, 16'h0000},
    {3'd6, 2'd0, 3'd0, 16'h8000, 16'h9000},
    {3'd7, 2'd0, 3'd1, 16'h5555, 16'h1111},
    {3'd5, 2'd0, 3'd0, 16'h0010, 16'h0000}
  };

  task automatic run_op(logic [2:0] m, logic [1:0] d, logic [RW-1:0] r,
                        logic [AW-1:0] a, logic [AW-1:0] p, int l);
    logic [AW-1:0] xea, xop, ptr;
    int xreads, lv, n;
    bit xerr;
    string t;
    t = tag(m);
    xerr = 1'b0;
    xreads = 1;
    case (m)
      3'd0: begin xea = a; xop = a; xreads = 0; end
      3'd3: begin xea = 16'(r); xop = regf(r); xreads = 0; end
      3'd1: xea = a;
      3'd2: begin
        lv = (d == 0) ? 1 : int'(d);
        ptr = a;
        for (int k = 0; k < lv; k++) ptr = memf(ptr);
        xea = ptr;
        xreads = lv + 1;
      end
      3'd4: xea = regf(r);
      3'd5: xea = a + regf(r);
      3'd6: xea = a + p;
      default: begin xea = '0; xop = '0; xreads = 0; xerr = 1'b1; end
    endcase
    if (xreads > 0) xop = memf(xea);
    @(negedge clk);
    lat = l; nreads = 0;
    mode = m; depth = d; rfield = r; afield = a; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(t, "done seen", 32'(done), 32'd1);
    chk(t, "operand", 32'(operand), 32'(xop));
    chk(t, "ea", 32'(ea), 32'(xea));
    chk(t, "memory reads", 32'(nreads), 32'(xreads));
    chk("R10", "err with done", 32'(err), 32'(xerr));
    if (xreads == 0) chk(t, "cycles to done", 32'(n), 32'd1);
    @(negedge clk);
    chk("R10", "done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "done in reset", 32'(done), 32'd0);
    chk("R12", "err in reset", 32'(err), 32'd0);
    chk("R12", "mem_req in reset", 32'(mem_req), 32'd0);
    chk("R12", "operand in reset", 32'(operand), 32'd0);
    chk("R12", "ea in reset", 32'(ea), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][39:37], VEC[i][36:35], VEC[i][34:32], VEC[i][31:16], VEC[i][15:0], i % 3);

    // R11: a start in mid-chain is ignored
    begin
      logic [AW-1:0] p;
      int n, nd;
      p = memf(memf(memf(16'h0777)));
      @(negedge clk);
      lat = 2; nreads = 0;
      mode = 3'd2; depth = 2'd3; afield = 16'h0777; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      mode = 3'd0; afield = 16'hBEEF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", "no done after busy start", 32'(done), 32'd0);
      n = 0; nd = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk("R11", "operand unaffected", 32'(operand), 32'(memf(p)));
      chk("R11", "ea unaffected", 32'(ea), 32'(p));
      chk("R11", "reads for chain", 32'(nreads), 32'd4);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (done) nd++;
      end
      chk("R11", "no extra done", 32'(nd), 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule